// File: doc/BRIEF.md
# AES Inverse Column-Mix Vector Unit

This execution unit applies the AES InvMixColumns transform to a 128-bit source operand and writes the result into the low 128 bits of a wider destination register. The register width is a parameter. Its typical use is to convert the middle round keys of an expanded key schedule, all but the first and the last, into the form the equivalent inverse cipher needs.

The bits of the destination above bit 127 depend on the encoding flavour of the operation. A legacy-encoded operation keeps their previous contents, taken from the current destination value the caller supplies. A VEX-encoded operation clears them. A VEX-encoded operation also checks a 4-bit reserved operand field. If that field does not hold all ones, the unit reports an undefined-opcode fault and suppresses the write. The unit raises no floating-point exceptions. One register stage sits between the request and the result.

Top module: `imc_exec_unit`

## Requirements
- R1: After synchronous reset, `out_valid`, `dst_we` and `ud_fault` are 0.
- R2: A request with `in_valid` high at a rising edge produces `out_valid` high for exactly one cycle after that edge. Without a request, `out_valid` is 0 in the next cycle.
- R3: Byte k of the source sits at bits 8k+7:8k. Column c is bytes 4c..4c+3, with byte 4c as row 0. Each output byte of a column is the GF(2^8) sum of the column bytes multiplied by a row of {0e,0b,0d,09}, rotated one place right per row. The field polynomial is 0x11B. The result goes to `dst_new[127:0]`.
- R4: A column with bytes (row 0 to row 3) 8e 4d a1 bc maps to db 13 53 45.
- R5: The transform undoes the forward MixColumns, whose matrix rows are {02,03,01,01} rotated. Applying it to a MixColumns output returns the original 128 bits.
- R6: With `vex_mode`=0, `dst_new[VLEN-1:128]` equals the `dst_old` upper bits of the request. The `vvvv` value is ignored and never causes a fault.
- R7: With `vex_mode`=1 and `vvvv`=4'b1111, `dst_new[VLEN-1:128]` is zero and no fault is raised.
- R8: With `vex_mode`=1 and `vvvv`≠4'b1111, `ud_fault` is 1, `dst_we` is 0 and `dst_new` equals the request's `dst_old`.
- R9: `dst_we` is 1 exactly when `out_valid` is 1 and `ud_fault` is 0. `ud_fault` is 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src | input | 128 | Source operand |
| dst_old | input | VLEN | Current destination register contents |
| vex_mode | input | 1 | 1 = VEX encoding, 0 = legacy encoding |
| vvvv | input | 4 | Reserved operand field, must be 4'b1111 under VEX |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| dst_we | output | 1 | Destination write enable |
| ud_fault | output | 1 | Undefined-opcode fault |
| dst_new | output | VLEN | New destination value |

## Verification
The hardest case to reach from the ports is the round trip. A generic random source says little about whether the four matrix rows are placed correctly. The bench therefore builds its own forward MixColumns with a bit-serial field multiply and feeds that result to the unit, so a correct unit must return the original random vector exactly. The fault path is driven with every non-all-ones `vvvv` value. Each of those requests carries a distinctive `dst_old`, which shows that the destination is passed through unchanged.

// File: rtl/imc_pkg.sv
package imc_pkg;

    localparam int          BLK_W      = 128;
    localparam int          COL_W      = 32;
    localparam int          N_COLS     = BLK_W / COL_W;
    localparam logic [3:0]  VVVV_LEGAL = 4'b1111;

    typedef enum logic {
        ENC_LEGACY = 1'b0,
        ENC_VEX    = 1'b1
    } enc_e;

    typedef struct packed {
        logic [7:0] r3;
        logic [7:0] r2;
        logic [7:0] r1;
        logic [7:0] r0;
    } column_t;

    // multiply by x modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    typedef struct packed {
        logic [7:0] m9;
        logic [7:0] mb;
        logic [7:0] md;
        logic [7:0] me;
    } prod_t;

    function automatic prod_t inv_products(input logic [7:0] a);
        logic [7:0] x2, x4, x8;
        prod_t p;
        x2   = xtime(a);
        x4   = xtime(x2);
        x8   = xtime(x4);
        p.m9 = x8 ^ a;
        p.mb = x8 ^ x2 ^ a;
        p.md = x8 ^ x4 ^ a;
        p.me = x8 ^ x4 ^ x2;
        return p;
    endfunction

endpackage

// File: rtl/imc_column.sv
module imc_column
    import imc_pkg::*;
(
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out
);

    column_t c_in, c_out;
    prod_t   p0, p1, p2, p3;

    assign c_in = column_t'(col_in);

    always_comb begin
        p0 = inv_products(c_in.r0);
        p1 = inv_products(c_in.r1);
        p2 = inv_products(c_in.r2);
        p3 = inv_products(c_in.r3);
        c_out.r0 = p0.me ^ p1.mb ^ p2.md ^ p3.m9;
        c_out.r1 = p0.m9 ^ p1.me ^ p2.mb ^ p3.md;
        c_out.r2 = p0.md ^ p1.m9 ^ p2.me ^ p3.mb;
        c_out.r3 = p0.mb ^ p1.md ^ p2.m9 ^ p3.me;
    end

    assign col_out = COL_W'(c_out);

endmodule

// File: rtl/imc_lane_merge.sv
module imc_lane_merge
    import imc_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic [BLK_W-1:0] low_res,
    input  logic [VLEN-1:0]  old_val,
    input  enc_e             enc,
    input  logic             fault,
    output logic [VLEN-1:0]  merged
);

    localparam int UPPER_W = VLEN - BLK_W;

    logic [BLK_W-1:0] low_sel;
    assign low_sel = fault ? old_val[BLK_W-1:0] : low_res;

    generate
        if (UPPER_W > 0) begin : g_upper
            logic [UPPER_W-1:0] up_sel;
            always_comb begin
                if (fault || enc == ENC_LEGACY) up_sel = old_val[VLEN-1:BLK_W];
                else                            up_sel = '0;
            end
            assign merged = {up_sel, low_sel};
        end else begin : g_no_upper
            logic unused_enc;
            assign unused_enc = (enc == ENC_VEX);
            assign merged     = low_sel;
        end
    endgenerate

endmodule

// File: rtl/imc_exec_unit.sv
module imc_exec_unit
    import imc_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [127:0]    src,
    input  logic [VLEN-1:0] dst_old,
    input  logic            vex_mode,
    input  logic [3:0]      vvvv,
    output logic            out_valid,
    output logic            dst_we,
    output logic            ud_fault,
    output logic [VLEN-1:0] dst_new
);

    localparam int UPPER_W = VLEN - BLK_W;

    initial begin
        if (VLEN < BLK_W || (VLEN % BLK_W) != 0)
            $error("VLEN must be a positive multiple of 128");
    end

    enc_e             enc;
    logic             fault_c;
    logic [BLK_W-1:0] imc_res;
    logic [VLEN-1:0]  merged;

    assign enc     = enc_e'(vex_mode);
    assign fault_c = (enc == ENC_VEX) && (vvvv != VVVV_LEGAL);

    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        imc_column u_col (
            .col_in  (src    [c*COL_W +: COL_W]),
            .col_out (imc_res[c*COL_W +: COL_W])
        );
    end

    imc_lane_merge #(.VLEN(VLEN)) u_merge (
        .low_res (imc_res),
        .old_val (dst_old),
        .enc     (enc),
        .fault   (fault_c),
        .merged  (merged)
    );

    logic            vld_q, flt_q;
    logic [VLEN-1:0] dst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            flt_q <= 1'b0;
            dst_q <= '0;
        end else begin
            vld_q <= in_valid;
            flt_q <= in_valid & fault_c;
            if (in_valid) dst_q <= merged;
        end
    end

    assign out_valid = vld_q;
    assign ud_fault  = flt_q;
    assign dst_we    = vld_q & ~flt_q;
    assign dst_new   = dst_q;

    AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                          // R2
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                        // R2
    AST_FAULT_ON_BAD_FIELD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vex_mode && vvvv != 4'b1111) |=> (ud_fault && !dst_we)); // R8
    AST_FAULT_KEEPS_DST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vex_mode && vvvv != 4'b1111) |=> dst_new == $past(dst_old)); // R8
    AST_LEGACY_NEVER_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !vex_mode) |=> !ud_fault);                           // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!dst_we && !ud_fault));                           // R9

    generate
        if (UPPER_W > 0) begin : g_upper_chk
            AST_LEGACY_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
                (in_valid && !vex_mode) |=>
                dst_new[VLEN-1:BLK_W] == $past(dst_old[VLEN-1:BLK_W]));   // R6
            AST_VEX_CLEARS_UPPER: assert property (@(posedge clk) disable iff (rst)
                (in_valid && vex_mode && vvvv == 4'b1111) |=>
                dst_new[VLEN-1:BLK_W] == '0);                             // R7
        end
    endgenerate

endmodule

// File: tb/test_imc_exec_unit.sv
module test_imc_exec_unit;

    localparam int  VLEN       = 256;
    localparam time CLK_PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [127:0]    src = '0;
    logic [VLEN-1:0] dst_old = '0;
    logic            vex_mode = 1'b0;
    logic [3:0]      vvvv = 4'b0000;
    logic            out_valid, dst_we, ud_fault;
    logic [VLEN-1:0] dst_new;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    imc_exec_unit #(.VLEN(VLEN)) i_imc_exec_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src(src),
        .dst_old(dst_old), .vex_mode(vex_mode), .vvvv(vvvv),
        .out_valid(out_valid), .dst_we(dst_we), .ud_fault(ud_fault),
        .dst_new(dst_new)
    );

    // bit-serial field multiply, independent of the unit's xtime chain
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] acc, sh;
        acc = '0;
        sh  = {1'b0, a};
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh << 1;
            if (sh[8]) sh = sh ^ 9'h11b;
        end
        return acc[7:0];
    endfunction

    function automatic logic [127:0] mat_apply(input logic [127:0] v, input logic [31:0] row);
        logic [127:0] r;
        logic [7:0]   k [4];
        k[0] = row[7:0]; k[1] = row[15:8]; k[2] = row[23:16]; k[3] = row[31:24];
        r = '0;
        for (int c = 0; c < 4; c++)
            for (int o = 0; o < 4; o++)
                for (int i = 0; i < 4; i++)
                    r[32*c+8*o +: 8] = r[32*c+8*o +: 8] ^
                        gmul(k[(i - o + 4) % 4], v[32*c+8*i +: 8]);
        return r;
    endfunction

    function automatic logic [127:0] mix_fwd(input logic [127:0] v);
        return mat_apply(v, 32'h01_01_03_02);
    endfunction

    function automatic logic [127:0] mix_inv(input logic [127:0] v);
        return mat_apply(v, 32'h09_0d_0b_0e);
    endfunction

    task automatic check(input bit ok, input string req, input logic [VLEN-1:0] act,
                         input logic [VLEN-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one request; returns after the result is visible
    task automatic issue(input logic [127:0] s, input logic [VLEN-1:0] old,
                         input logic vx, input logic [3:0] vf);
        @(negedge clk);
        src = s; dst_old = old; vex_mode = vx; vvvv = vf; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check(out_valid == 1'b0, "R1 out_valid", VLEN'(out_valid), '0);
        check(dst_we == 1'b0,    "R1 dst_we",    VLEN'(dst_we),    '0);
        check(ud_fault == 1'b0,  "R1 ud_fault",  VLEN'(ud_fault),  '0);
    endtask

    task automatic t_latency();
        issue(128'h1, '0, 1'b0, 4'h0);
        check(out_valid == 1'b1, "R2 result strobe", VLEN'(out_valid), 1);
        @(negedge clk);
        check(out_valid == 1'b0, "R2 strobe one cycle", VLEN'(out_valid), 0);
        check(dst_we == 1'b0 && ud_fault == 1'b0, "R9 idle quiet",
              VLEN'({dst_we, ud_fault}), 0);
    endtask

    task automatic t_known_column();
        logic [127:0] s, e;
        s = {4{32'hbc_a1_4d_8e}};
        e = {4{32'h45_53_13_db}};
        issue(s, '0, 1'b1, 4'hf);
        check(dst_new[127:0] == e, "R4 known column", VLEN'(dst_new[127:0]), VLEN'(e));
        check(dst_we == 1'b1, "R9 write enable", VLEN'(dst_we), 1);
    endtask

    task automatic t_random_direct();
        for (int n = 0; n < 20; n++) begin
            logic [127:0] s;
            s = {$urandom, $urandom, $urandom, $urandom};
            issue(s, '0, 1'b0, 4'hf);
            check(dst_new[127:0] == mix_inv(s), "R3 transform",
                  VLEN'(dst_new[127:0]), VLEN'(mix_inv(s)));
        end
        issue(128'h0, '1, 1'b0, 4'h0);
        check(dst_new[127:0] == '0, "R3 zero source", VLEN'(dst_new[127:0]), 0);
    endtask

    task automatic t_round_trip();
        for (int n = 0; n < 20; n++) begin
            logic [127:0] v;
            v = {$urandom, $urandom, $urandom, $urandom};
            issue(mix_fwd(v), '0, 1'b1, 4'hf);
            check(dst_new[127:0] == v, "R5 round trip", VLEN'(dst_new[127:0]), VLEN'(v));
        end
    endtask

    task automatic t_legacy_upper();
        for (int f = 0; f < 16; f++) begin
            logic [VLEN-1:0] old;
            old = {$urandom, $urandom, $urandom, $urandom,
                   $urandom, $urandom, $urandom, $urandom};
            issue(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, old, 1'b0, 4'(f));
            check(dst_new[VLEN-1:128] == old[VLEN-1:128], "R6 upper kept",
                  dst_new, old);
            check(ud_fault == 1'b0 && dst_we == 1'b1, "R6 no fault legacy",
                  VLEN'({ud_fault, dst_we}), 1);
        end
    endtask

    task automatic t_vex_upper();
        issue(128'h5a5a, '1, 1'b1, 4'hf);
        check(dst_new[VLEN-1:128] == '0, "R7 upper cleared", dst_new, '0);
        check(ud_fault == 1'b0 && dst_we == 1'b1, "R7 no fault",
              VLEN'({ud_fault, dst_we}), 1);
    endtask

    task automatic t_vex_fault();
        for (int f = 0; f < 15; f++) begin
            logic [VLEN-1:0] old;
            old = {8{32'hc0de_0000 | 32'(f)}};
            issue(128'h1234, old, 1'b1, 4'(f));
            check(ud_fault == 1'b1, "R8 fault raised", VLEN'(ud_fault), 1);
            check(dst_we == 1'b0, "R8 no write", VLEN'(dst_we), 0);
            check(dst_new == old, "R8 dst unchanged", dst_new, old);
        end
        @(negedge clk);
        check(ud_fault == 1'b0, "R9 fault clears when idle", VLEN'(ud_fault), 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latency();
        t_known_column();
        t_random_direct();
        t_round_trip();
        t_legacy_upper();
        t_vex_upper();
        t_vex_fault();
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule